// File: doc/BRIEF.md
# Inverted Byte-Sum Checksum Engine

This block protects a contiguous range of a byte-wide non-volatile RAM with a 16-bit checksum. It reaches the RAM through a synchronous single-port interface: a request with an address, an optional write, and read data that returns one cycle after a read request. The engine adds up every byte between a start and an end address, both included. It keeps only the low 16 bits of the sum and takes their bitwise complement. That complement is the checksum.

Two commands exist. A verify command computes the checksum, reads the two stored checksum bytes, and reports whether they match. A set command computes the same value and writes it to the two checksum bytes. The high byte goes to the given location and the low byte to the next address. With each command, the caller supplies the range bounds, the checksum location and the command kind in a single cycle. The caller then waits for the one-cycle completion pulse.

Top module: `nvram_cksum_engine`

## Requirements
- R1: After reset, `busy`, `done`, `pass` and `mem_req` are 0 and `calc_cks` is 0x0000.
- R2: `calc_cks` at completion equals the bitwise complement of the sum of all bytes from `cmd_start` to `cmd_end` inclusive, with the sum truncated to 16 bits (sums above 0xFFFF wrap).
- R3: If `cmd_start` is greater than `cmd_end`, no byte is summed and `calc_cks` is 0xFFFF.
- R4: A set command produces exactly two writes in consecutive cycles. The first write puts `calc_cks[15:8]` at `cmd_loc`. The second puts `calc_cks[7:0]` at `cmd_loc`+1, and that address wraps modulo 2^ADDR_W. On completion of a set command, `pass` is 1.
- R5: On completion of a verify command, `pass` is 1 exactly when ({byte at `cmd_loc`} << 8 | byte at `cmd_loc`+1) equals `calc_cks`; otherwise it is 0.
- R6: The engine makes at most one RAM access per cycle and accesses the RAM only while `busy` is high. A verify command makes exactly (end − start + 1) + 2 reads when start ≤ end, and 2 reads otherwise.
- R7: `busy` rises in the cycle after a command is accepted and stays high until completion. `done` is a one-cycle pulse in the cycle in which `busy` has fallen.
- R8: A command presented while `busy` is high is ignored. It does not change the outcome of the running command and produces no extra `done`.
- R9: `pass` and `calc_cks` keep their completion values until the next command is accepted. A command presented in the very cycle `done` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, accepted when not busy |
| cmd_set | input | 1 | 1 = set (write checksum), 0 = verify |
| cmd_start | input | ADDR_W | First address of the summed range |
| cmd_end | input | ADDR_W | Last address of the summed range (inclusive) |
| cmd_loc | input | ADDR_W | Address of the checksum high byte |
| mem_req | output | 1 | RAM access request |
| mem_we | output | 1 | RAM write enable (valid with mem_req) |
| mem_addr | output | ADDR_W | RAM address |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, one cycle after a read request |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result of the last completed command |
| calc_cks | output | 16 | Checksum computed by the last completed command |

## Verification
Two events can share a cycle. In the first, completion raises `done` and loads `pass` and `calc_cks` while the caller presents a new command. The bench drives a second command exactly in the cycle `done` is seen high. It then checks that the new command starts at once and that the earlier result was intact when it was sampled. In the second, a new command overlaps a command that is still summing. The bench injects one mid-run and judges it by the final checksum, which must belong to the first range, and by a count of exactly one `done` pulse. The RAM model also logs every write and counts reads, so the order and the number of accesses are checked at the ports.

// File: rtl/cksum_pkg.sv
package cksum_pkg;
    localparam int BYTE_W = 8;
    localparam int CKS_W  = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SUM,
        ST_TAIL,
        ST_CK_HI,
        ST_CK_LO,
        ST_CK_WAIT
    } eng_state_e;

    // Meaning of the read data returning in the following cycle
    typedef enum logic [1:0] {
        TAG_NONE,
        TAG_SUM,
        TAG_HI,
        TAG_LO
    } rd_tag_e;
endpackage

// File: rtl/cksum_accum.sv
module cksum_accum
    import cksum_pkg::*;
#(
    parameter int SUM_W = CKS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add_en,
    input  logic [BYTE_W-1:0] add_byte,
    output logic [SUM_W-1:0]  sum_q
);
    localparam int PAD_W = SUM_W - BYTE_W;

    logic [SUM_W-1:0] sum_d;

    always_comb begin
        sum_d = sum_q;
        if (clr) begin
            sum_d = '0;
        end else if (add_en) begin
            // carries beyond SUM_W are dropped by the register width
            sum_d = sum_q + {{PAD_W{1'b0}}, add_byte};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end
endmodule

// File: rtl/cksum_match.sv
module cksum_match
    import cksum_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_hi,
    input  logic [BYTE_W-1:0] rd_byte,
    input  logic [CKS_W-1:0]  expect_cks,
    output logic              match
);
    logic [BYTE_W-1:0] hi_d, hi_q;

    always_comb begin
        hi_d = hi_q;
        if (cap_hi) hi_d = rd_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hi_q <= '0;
        else        hi_q <= hi_d;
    end

    // stored value: high byte shifted up, low byte arriving now
    assign match = ({hi_q, rd_byte} == expect_cks);
endmodule

// File: rtl/nvram_cksum_engine.sv
module nvram_cksum_engine
    import cksum_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_set,
    input  logic [ADDR_W-1:0] cmd_start,
    input  logic [ADDR_W-1:0] cmd_end,
    input  logic [ADDR_W-1:0] cmd_loc,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic [CKS_W-1:0]  calc_cks
);
    typedef struct packed {
        eng_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] last;
        logic [ADDR_W-1:0] loc;
        logic              is_set;
        rd_tag_e           rtag;
        logic              done;
        logic              pass;
        logic [CKS_W-1:0]  cks;
    } eng_regs_t;

    localparam eng_regs_t REGS_RST = '{
        st: ST_IDLE, addr: '0, last: '0, loc: '0, is_set: 1'b0,
        rtag: TAG_NONE, done: 1'b0, pass: 1'b0, cks: '0
    };

    eng_regs_t        r_q, r_d;
    logic             acc_clr;
    logic             acc_en;
    logic [CKS_W-1:0] sum_q;
    logic [CKS_W-1:0] cks_now;
    logic             match;

    assign acc_en  = (r_q.rtag == TAG_SUM);
    assign cks_now = ~sum_q;

    cksum_accum #(.SUM_W(CKS_W)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (acc_clr),
        .add_en   (acc_en),
        .add_byte (mem_rdata),
        .sum_q    (sum_q)
    );

    cksum_match u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_hi     (r_q.rtag == TAG_HI),
        .rd_byte    (mem_rdata),
        .expect_cks (cks_now),
        .match      (match)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.rtag  = TAG_NONE;
        acc_clr   = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = r_q.addr;
        mem_wdata = '0;

        unique case (r_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    r_d.addr   = cmd_start;
                    r_d.last   = cmd_end;
                    r_d.loc    = cmd_loc;
                    r_d.is_set = cmd_set;
                    r_d.pass   = 1'b0;
                    acc_clr    = 1'b1;
                    r_d.st     = (cmd_start > cmd_end) ? ST_TAIL : ST_SUM;
                end
            end
            ST_SUM: begin
                mem_req  = 1'b1;
                mem_addr = r_q.addr;
                r_d.rtag = TAG_SUM;
                if (r_q.addr == r_q.last) r_d.st = ST_TAIL;
                else                      r_d.addr = r_q.addr + 1'b1;
            end
            ST_TAIL: begin
                // last summed byte lands in the accumulator this cycle
                r_d.st = ST_CK_HI;
            end
            ST_CK_HI: begin
                mem_req  = 1'b1;
                mem_addr = r_q.loc;
                if (r_q.is_set) begin
                    mem_we    = 1'b1;
                    mem_wdata = cks_now[CKS_W-1 -: BYTE_W];
                end else begin
                    r_d.rtag = TAG_HI;
                end
                r_d.st = ST_CK_LO;
            end
            ST_CK_LO: begin
                mem_req  = 1'b1;
                mem_addr = r_q.loc + 1'b1;
                if (r_q.is_set) begin
                    mem_we    = 1'b1;
                    mem_wdata = cks_now[BYTE_W-1:0];
                    r_d.pass  = 1'b1;
                    r_d.cks   = cks_now;
                    r_d.done  = 1'b1;
                    r_d.st    = ST_IDLE;
                end else begin
                    r_d.rtag = TAG_LO;
                    r_d.st   = ST_CK_WAIT;
                end
            end
            ST_CK_WAIT: begin
                r_d.pass = match;
                r_d.cks  = cks_now;
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign busy     = (r_q.st != ST_IDLE);
    assign done     = r_q.done;
    assign pass     = r_q.pass;
    assign calc_cks = r_q.cks;
endmodule

// File: rtl/cksum_checker.sv
module cksum_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              busy,
    input logic              done,
    input logic              pass,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R7

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> busy); // R7

    AST_REQ_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy); // R6

    AST_WRITE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !$past(mem_req && mem_we))
        |=> (mem_req && mem_we && (mem_addr == $past(mem_addr) + 1'b1))); // R4

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cmd_valid) |=> $stable(pass)); // R9
endmodule

bind nvram_cksum_engine cksum_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .done      (done),
    .pass      (pass),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr)
);

// File: tb/nvram_cksum_engine_tb.sv
`timescale 1ns/1ps
module nvram_cksum_engine_tb;
    localparam int AW    = 9;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_set = 1'b0;
    logic [AW-1:0] cmd_start = '0, cmd_end = '0, cmd_loc = '0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata;
    logic          busy, done, pass;
    logic [15:0]   calc_cks;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    nvram_cksum_engine #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_set(cmd_set),
        .cmd_start(cmd_start), .cmd_end(cmd_end), .cmd_loc(cmd_loc),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .pass(pass), .calc_cks(calc_cks)
    );

    // RAM model with access log
    logic [7:0]    mem [0:DEPTH-1];
    logic [7:0]    rd_q = '0;
    int            rd_cnt = 0;
    int            wr_cnt = 0;
    int            done_cnt = 0;
    logic [AW-1:0] wa_old = '0, wa_new = '0;
    logic [7:0]    wd_old = '0, wd_new = '0;
    assign mem_rdata = rd_q;

    always @(posedge clk) begin
        if (done) done_cnt <= done_cnt + 1;
        if (mem_req) begin
            if (mem_we) begin
                mem[mem_addr] <= mem_wdata;
                wa_old <= wa_new; wd_old <= wd_new;
                wa_new <= mem_addr; wd_new <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                rd_q   <= mem[mem_addr];
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model_cks(input int s, input int e);
        int sum = 0;
        for (int i = s; i <= e; i++) sum += int'(mem[i]);
        return ~sum[15:0];
    endfunction

    task automatic fill_pattern();
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
    endtask

    task automatic issue(input bit set, input int s, input int e, input int l);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_set = set;
        cmd_start = AW'(s); cmd_end = AW'(e); cmd_loc = AW'(l);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(done, "R7 done reached", int'(done), 1);
    endtask

    task automatic run(input bit set, input int s, input int e, input int l);
        issue(set, s, e, l);
        chk(busy == 1'b1, "R7 busy after accept", int'(busy), 1);
        wait_done();
    endtask

    initial begin
        int rc, wc, dc;
        logic [15:0] ex, held;
        fill_pattern();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 0, "R1 busy", int'(busy), 0);
        chk(done == 0, "R1 done", int'(done), 0);
        chk(pass == 0, "R1 pass", int'(pass), 0);
        chk(mem_req == 0, "R1 mem_req", int'(mem_req), 0);
        chk(calc_cks == 0, "R1 calc_cks", int'(calc_cks), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 / R3 / R6 sweep of small ranges, including start > end
        for (int s = 0; s < 20; s++) begin
            for (int e = 0; e < 20; e++) begin
                rc = rd_cnt;
                run(1'b0, s, e, 400);
                ex = (s > e) ? 16'hFFFF : model_cks(s, e);
                chk(calc_cks == ex, (s > e) ? "R3 empty range" : "R2 sum",
                    int'(calc_cks), int'(ex));
                chk(rd_cnt - rc == ((s > e) ? 2 : e - s + 3), "R6 read count",
                    rd_cnt - rc, (s > e) ? 2 : e - s + 3);
                @(negedge clk);
                chk(done == 0, "R7 done one cycle", int'(done), 0);
            end
        end

        // R2 truncation: whole RAM at 0xFF exceeds 16 bits
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
        run(1'b0, 0, DEPTH - 1, 5);
        ex = 16'(~(DEPTH * 255));
        chk(calc_cks == ex, "R2 truncated sum", int'(calc_cks), int'(ex));
        chk(pass == 0, "R5 mismatch on all-ones", int'(pass), 0);
        fill_pattern();

        // R4 set: high byte at loc, low byte at loc+1, in that order
        wc = wr_cnt;
        ex = model_cks(3, 40);
        run(1'b1, 3, 40, 300);
        chk(wr_cnt - wc == 2, "R4 write count", wr_cnt - wc, 2);
        chk(wa_old == 300 && wd_old == ex[15:8], "R4 high first",
            int'({wa_old, wd_old}), int'({9'd300, ex[15:8]}));
        chk(wa_new == 301 && wd_new == ex[7:0], "R4 low second",
            int'({wa_new, wd_new}), int'({9'd301, ex[7:0]}));
        chk(pass == 1, "R4 set pass", int'(pass), 1);

        // R5 verify passes, then fails after corruption
        run(1'b0, 3, 40, 300);
        chk(pass == 1, "R5 match", int'(pass), 1);
        mem[17] = mem[17] ^ 8'h01;
        run(1'b0, 3, 40, 300);
        chk(pass == 0, "R5 corrupted byte", int'(pass), 0);
        mem[17] = mem[17] ^ 8'h01;
        mem[301] = mem[301] ^ 8'h80;
        run(1'b0, 3, 40, 300);
        chk(pass == 0, "R5 corrupted low byte", int'(pass), 0);

        // R4 wrap of the low-byte address
        ex = model_cks(100, 120);
        run(1'b1, 100, 120, DEPTH - 1);
        chk(wa_old == AW'(DEPTH - 1) && wa_new == 0, "R4 wrap addr",
            int'({wa_old, wa_new}), int'({AW'(DEPTH - 1), AW'(0)}));
        chk(mem[DEPTH-1] == ex[15:8] && mem[0] == ex[7:0], "R4 wrap data",
            int'({mem[DEPTH-1], mem[0]}), int'(ex));
        run(1'b0, 100, 120, DEPTH - 1);
        chk(pass == 1, "R5 wrap verify", int'(pass), 1);

        // R9 result held while idle
        held = calc_cks;
        repeat (6) @(negedge clk);
        chk(calc_cks == held && pass == 1, "R9 hold", int'(calc_cks), int'(held));

        // R8 command during busy is ignored
        fill_pattern();
        dc = done_cnt;
        issue(1'b0, 0, 30, 400);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_set = 1'b1;
        cmd_start = AW'(0); cmd_end = AW'(5); cmd_loc = AW'(200);
        @(negedge clk);
        cmd_valid = 1'b0;
        wc = wr_cnt;
        wait_done();
        ex = model_cks(0, 30);
        chk(calc_cks == ex, "R8 first command result", int'(calc_cks), int'(ex));
        repeat (40) @(negedge clk);
        chk(done_cnt - dc == 1, "R8 single done", done_cnt - dc, 1);
        chk(wr_cnt == wc, "R8 no writes", wr_cnt - wc, 0);

        // R9 command accepted in the done cycle
        issue(1'b0, 10, 12, 400);
        wait_done();
        ex = model_cks(10, 12);
        chk(calc_cks == ex, "R9 result at done", int'(calc_cks), int'(ex));
        cmd_valid = 1'b1; cmd_set = 1'b0;
        cmd_start = AW'(50); cmd_end = AW'(20); cmd_loc = AW'(400);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy == 1, "R9 accept in done cycle", int'(busy), 1);
        wait_done();
        chk(calc_cks == 16'hFFFF, "R3 back-to-back empty", int'(calc_cks), 16'hFFFF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule